// File: doc/BRIEF.md
# Coprocessor two-word load/store sequencer

This block sits between a bank of sixteen 64-bit coprocessor registers and a 32-bit memory data path. It steers each memory data beat of a coprocessor load or store into or out of the correct 32-bit half of the register named by the instruction. A long transfer carries a full 64-bit register over two consecutive data beats. A short transfer carries a single word.

Where each word lands depends on three things: the transfer length, an endianness input and a data type input. Long transfers swap the order of the halves with endianness. Short float transfers use the upper half. Short integer transfers use the lower half, and a short integer load sign-extends the word into the whole register. Every accepted beat gets a response: increment (another beat follows) or done. A beat that is not in a data phase clears the beat position and answers done.

Beats use a valid/ready handshake. A beat is accepted in any cycle where `beat_valid` and `beat_ready` are both high. `beat_ready` is low during reset and high in every cycle after it, so the block never applies back-pressure once it is running. The response (`resp_valid`, `resp_done`) and the store word (`st_data`) belong to the accepted beat and are valid in the same cycle. Load data is written to the bank at the clock edge that ends that cycle. Address generation and the memory itself are not part of this block. The length and index inputs are taken from instruction bit 22 and bits 15..12, which are decoded upstream. A separate read port lets the host inspect any register.

Top module: `cpls_sequencer`

## Requirements
- R1: In reset, `beat_ready` is 0 and every register reads as zero. After reset, the first long data beat is treated as a first beat.
- R2: The bank holds 16 registers of 64 bits. Bits 63..32 form the upper half and bits 31..0 the lower half. `host_data` shows register `host_idx` combinationally, including any write from the previous clock edge.
- R3: `reg_sel` (instruction bits 15..12) selects the register. `len_sel` (instruction bit 22) set to 1 selects a long transfer and 0 a short one.
- R4: For a long load with `big_endian`=1, the first beat writes the upper half and the second beat writes the lower half. With `big_endian`=0 the order is reversed. The other half is left unchanged by each beat.
- R5: For a long store, `st_data` returns the upper half on the first beat and the lower half on the second when `big_endian`=1, and the reverse order when `big_endian`=0.
- R6: `resp_done` is 0 (increment) on the first beat of a long transfer and 1 (done) on the second. It is 1 on every short beat.
- R7: An accepted beat with `data_phase`=0 answers `resp_done`=1, drives `st_data` to 0, writes nothing, and makes the next long data beat a first beat.
- R8: With `is_int`=0 (float), a short load writes only the upper half and leaves the lower half unchanged. A short store returns the upper half.
- R9: With `is_int`=1 (integer), a short load writes the word to the lower half and copies its bit 31 into all 32 upper bits. A short store returns the lower half.
- R10: `beat_ready` is 1 in every cycle after reset, and `resp_valid` equals `beat_valid` in those cycles. A cycle with `beat_valid`=0 changes no register and keeps the beat position. `st_data` is 0 except on an accepted store data beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| beat_valid | input | 1 | A beat is presented |
| beat_ready | output | 1 | Beat can be accepted (high after reset) |
| data_phase | input | 1 | 1: data beat, 0: non-data phase |
| is_store | input | 1 | 1: store (register to memory), 0: load |
| is_int | input | 1 | 1: integer data, 0: float data |
| big_endian | input | 1 | 1: big-endian half order for long transfers |
| len_sel | input | 1 | Instruction bit 22: 1 long, 0 short |
| reg_sel | input | 4 | Instruction bits 15..12: register index |
| ld_data | input | 32 | Word from memory for loads |
| st_data | output | 32 | Word to memory for stores |
| resp_valid | output | 1 | Response belongs to an accepted beat |
| resp_done | output | 1 | 1: done, 0: increment |
| host_idx | input | 4 | Register selected for host inspection |
| host_data | output | 64 | Contents of register `host_idx` |

## Verification
The assertions assume that a long transfer is presented as two accepted data beats with the same register, type, direction and endianness, though a non-data phase may interrupt the pair and restart it. They also assume that the inputs are steady while a beat is accepted. The stimulus draws transfers from $urandom with a fixed seed. Each long transfer is generated as a matched pair of beats, occasionally with a non-data phase placed between the two. Idle cycles and host reads are mixed in at random. Directed sequences cover both endianness orders, sign extension of negative and positive words, and float loads that must leave the lower half untouched.

// File: rtl/cpls_pkg.sv
package cpls_pkg;
  // Response encoding of each accepted beat
  typedef enum logic {
    RESP_INC  = 1'b0,
    RESP_DONE = 1'b1
  } resp_e;

  // A long-transfer beat targets the upper half on the first beat in
  // big-endian order and on the second beat in little-endian order.
  function automatic logic long_beat_upper(input logic second_beat, input logic big_end);
    return second_beat ^ big_end;
  endfunction
endpackage

// File: rtl/cpls_regbank.sv
module cpls_regbank #(
  parameter  int NREG   = 16,
  parameter  int WORD_W = 32,
  localparam int IDX_W  = $clog2(NREG),
  localparam int REG_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_hi_en,
  input  logic              wr_lo_en,
  input  logic [WORD_W-1:0] wr_hi_data,
  input  logic [WORD_W-1:0] wr_lo_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [REG_W-1:0]  rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [REG_W-1:0]  rd_b_data
);
  logic [REG_W-1:0] reg_view [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [WORD_W-1:0] hi_q, lo_q;
    logic              hit;
    assign hit = (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end else begin
        if (hit && wr_hi_en) hi_q <= wr_hi_data;
        if (hit && wr_lo_en) lo_q <= wr_lo_data;
      end
    end

    assign reg_view[i] = {hi_q, lo_q};
  end

  assign rd_a_data = reg_view[rd_a_idx];
  assign rd_b_data = reg_view[rd_b_idx];

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hi_en || wr_lo_en) |=> ($stable(rd_b_data) || (rd_b_idx != $past(rd_b_idx))));
endmodule

// File: rtl/cpls_beat_ctrl.sv
module cpls_beat_ctrl
  import cpls_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic beat_valid,
  output logic beat_ready,
  input  logic data_phase,
  input  logic is_store,
  input  logic is_int,
  input  logic is_long,
  input  logic big_endian,
  output logic resp_done,
  output logic wr_hi_en,
  output logic wr_lo_en,
  output logic rd_upper
);
  logic  ready_q;
  logic  second_q;
  logic  accept, xfer, long_up;
  resp_e resp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign beat_ready = ready_q;

  assign accept  = beat_valid && ready_q;
  assign xfer    = accept && data_phase;
  assign long_up = long_beat_upper(second_q, big_endian);

  always_comb begin
    resp = RESP_DONE;
    if (data_phase && is_long && !second_q) resp = RESP_INC;
  end
  assign resp_done = (resp == RESP_DONE);

  // Half steering: long beats follow endianness, short ones follow type
  always_comb begin
    wr_hi_en = 1'b0;
    wr_lo_en = 1'b0;
    rd_upper = is_long ? long_up : !is_int;
    if (xfer && !is_store) begin
      if (is_long) begin
        wr_hi_en = long_up;
        wr_lo_en = !long_up;
      end else begin
        wr_hi_en = 1'b1;
        wr_lo_en = is_int;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      second_q <= 1'b0;
    else if (accept) second_q <= (data_phase && is_long) ? !second_q : 1'b0;
  end

  // R6
  long_pair_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && is_long && $past(xfer && is_long && !resp_done)) |-> resp_done);
  // R7
  nondata_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !data_phase) |=> !second_q);
  // R10
  idle_keeps_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (second_q == $past(second_q)));
endmodule

// File: rtl/cpls_sequencer.sv
module cpls_sequencer #(
  parameter  int NREG   = 16,
  parameter  int WORD_W = 32,
  localparam int IDX_W  = $clog2(NREG),
  localparam int REG_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_valid,
  output logic              beat_ready,
  input  logic              data_phase,
  input  logic              is_store,
  input  logic              is_int,
  input  logic              big_endian,
  input  logic              len_sel,
  input  logic [IDX_W-1:0]  reg_sel,
  input  logic [WORD_W-1:0] ld_data,
  output logic [WORD_W-1:0] st_data,
  output logic              resp_valid,
  output logic              resp_done,
  input  logic [IDX_W-1:0]  host_idx,
  output logic [REG_W-1:0]  host_data
);
  logic              wr_hi_en, wr_lo_en, rd_upper;
  logic [WORD_W-1:0] wr_hi_data;
  logic [REG_W-1:0]  sel_data;

  cpls_beat_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .data_phase (data_phase),
    .is_store   (is_store),
    .is_int     (is_int),
    .is_long    (len_sel),
    .big_endian (big_endian),
    .resp_done  (resp_done),
    .wr_hi_en   (wr_hi_en),
    .wr_lo_en   (wr_lo_en),
    .rd_upper   (rd_upper)
  );

  // Short integer loads fill the upper half with the word's sign
  assign wr_hi_data = (!len_sel && is_int) ? {WORD_W{ld_data[WORD_W-1]}} : ld_data;

  cpls_regbank #(.NREG(NREG), .WORD_W(WORD_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_idx     (reg_sel),
    .wr_hi_en   (wr_hi_en),
    .wr_lo_en   (wr_lo_en),
    .wr_hi_data (wr_hi_data),
    .wr_lo_data (ld_data),
    .rd_a_idx   (reg_sel),
    .rd_a_data  (sel_data),
    .rd_b_idx   (host_idx),
    .rd_b_data  (host_data)
  );

  assign resp_valid = beat_valid && beat_ready;
  assign st_data    = (resp_valid && data_phase && is_store)
                    ? (rd_upper ? sel_data[REG_W-1:WORD_W] : sel_data[WORD_W-1:0])
                    : '0;

  // R8
  float_short_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && data_phase && !is_store && !len_sel && !is_int) |-> !wr_lo_en);
  // R9
  int_short_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_en && wr_lo_en) |-> (wr_hi_data == {WORD_W{ld_data[WORD_W-1]}}));
  // R7
  nondata_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !data_phase) |-> (!wr_hi_en && !wr_lo_en && resp_done));
endmodule

// File: tb/tb_cpls_sequencer.sv
module tb_cpls_sequencer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        beat_valid = 1'b0, data_phase = 1'b0, is_store = 1'b0, is_int = 1'b0;
  logic        big_endian = 1'b0, len_sel = 1'b0;
  logic [3:0]  reg_sel = '0, host_idx = '0;
  logic [31:0] ld_data = '0;
  logic        beat_ready, resp_valid, resp_done;
  logic [31:0] st_data;
  logic [63:0] host_data;

  int  n_chk = 0, n_bad = 0;
  bit  finished = 0;
  logic [63:0] mdl [16];
  bit  mpos = 0;

  always #(CLK_P/2) clk = ~clk;

  cpls_sequencer dut (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .data_phase(data_phase), .is_store(is_store), .is_int(is_int),
    .big_endian(big_endian), .len_sel(len_sel), .reg_sel(reg_sel),
    .ld_data(ld_data), .st_data(st_data), .resp_valid(resp_valid),
    .resp_done(resp_done), .host_idx(host_idx), .host_data(host_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected response: increment only on the first beat of a long data transfer
  function automatic bit exp_done_f(input bit dp, input bit lg, input bit pos);
    if (dp && lg && !pos) return 1'b0;
    return 1'b1;
  endfunction

  // Expected half for a beat: 1 means upper
  function automatic bit exp_upper_f(input bit lg, input bit it, input bit be, input bit pos);
    if (lg) begin
      if (!pos) return be;   // first beat: upper when big-endian
      return !be;            // second beat: upper when little-endian
    end
    return !it;              // short: float upper, integer lower
  endfunction

  task automatic beat(input bit dp, input bit st, input bit it, input bit be, input bit lg,
                      input logic [3:0] idx, input logic [31:0] ld, input string tag);
    bit          up, ed;
    logic [31:0] es;
    @(negedge clk);
    beat_valid = 1'b1; data_phase = dp; is_store = st; is_int = it;
    big_endian = be; len_sel = lg; reg_sel = idx; ld_data = ld;
    #(CLK_P/4);
    ed = exp_done_f(dp, lg, mpos);
    up = exp_upper_f(lg, it, be, mpos);
    es = (dp && st) ? (up ? mdl[idx][63:32] : mdl[idx][31:0]) : 32'h0;
    chk(resp_valid === 1'b1, {tag, " R10 resp_valid"}, 64'(resp_valid), 64'd1);
    chk(resp_done === ed, {tag, " R6 resp_done"}, 64'(resp_done), 64'(ed));
    chk(st_data === es, {tag, " R5 st_data"}, 64'(st_data), 64'(es));
    @(posedge clk);
    if (dp && !st) begin
      if (lg) begin
        if (up) mdl[idx][63:32] = ld; else mdl[idx][31:0] = ld;
      end else if (it) mdl[idx] = {{32{ld[31]}}, ld};
      else mdl[idx][63:32] = ld;
    end
    mpos = (dp && lg) ? !mpos : 1'b0;
    #1 beat_valid = 1'b0;
  endtask

  task automatic host_chk(input logic [3:0] idx, input string tag);
    @(negedge clk);
    beat_valid = 1'b0; host_idx = idx;
    #(CLK_P/4);
    chk(host_data === mdl[idx], {tag, " R2 host_data"}, host_data, mdl[idx]);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C9A));
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    // R1: reset state
    #(CLK_P*2 + 2);
    chk(beat_ready === 1'b0, "R1 ready in reset", 64'(beat_ready), 64'd0);
    host_idx = 4'd0;  #1 chk(host_data === 64'd0, "R1 reg0 zero", host_data, 64'd0);
    host_idx = 4'd15; #1 chk(host_data === 64'd0, "R1 reg15 zero", host_data, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1
    chk(beat_ready === 1'b1, "R10 ready after reset", 64'(beat_ready), 64'd1);

    // R4 / R3: long loads in both orders
    beat(1, 0, 0, 1, 1, 4'd3, 32'hAAAA_0001, "R1 R4 be first");
    beat(1, 0, 0, 1, 1, 4'd3, 32'hBBBB_0002, "R4 be second");
    host_chk(4'd3, "R4 be");
    chk(mdl[3] === 64'hAAAA_0001_BBBB_0002, "R4 be model", mdl[3], 64'hAAAA_0001_BBBB_0002);
    beat(1, 0, 1, 0, 1, 4'd12, 32'h1111_2222, "R4 le first");
    beat(1, 0, 1, 0, 1, 4'd12, 32'h3333_4444, "R4 le second");
    host_chk(4'd12, "R3 R4 le");
    host_chk(4'd13, "R3 neighbour untouched");
    // R5: long stores in both orders
    beat(1, 1, 0, 1, 1, 4'd3, 32'h0, "R5 be first");
    beat(1, 1, 0, 1, 1, 4'd3, 32'h0, "R5 be second");
    beat(1, 1, 1, 0, 1, 4'd3, 32'h0, "R5 le first");
    beat(1, 1, 1, 0, 1, 4'd3, 32'h0, "R5 le second");
    // R8: short float load keeps lower half
    beat(1, 0, 0, 0, 0, 4'd3, 32'hC0DE_F00D, "R8 float load");
    host_chk(4'd3, "R8 lower kept");
    beat(1, 1, 0, 1, 0, 4'd3, 32'h0, "R8 float store");
    // R9: short integer load sign extension, both signs
    beat(1, 0, 1, 0, 0, 4'd7, 32'h8000_0005, "R9 neg load");
    host_chk(4'd7, "R9 neg sext");
    beat(1, 0, 1, 1, 0, 4'd8, 32'h7FFF_FFFF, "R9 pos load");
    host_chk(4'd8, "R9 pos sext");
    beat(1, 1, 1, 0, 0, 4'd7, 32'h0, "R9 int store");
    // R7: non-data phase in the middle of a long transfer
    beat(1, 0, 0, 1, 1, 4'd9, 32'h0000_00F1, "R7 first");
    beat(0, 1, 0, 1, 1, 4'd9, 32'hDEAD_BEEF, "R7 nondata");
    host_chk(4'd9, "R7 no write");
    beat(1, 0, 0, 1, 1, 4'd9, 32'h0000_00F2, "R7 restart first");
    beat(1, 0, 0, 1, 1, 4'd9, 32'h0000_00F3, "R7 restart second");
    host_chk(4'd9, "R7 after restart");
    // R10: idle cycle between long beats keeps position
    beat(1, 0, 1, 0, 1, 4'd10, 32'h0123_4567, "R10 first");
    host_chk(4'd10, "R10 idle");
    beat(1, 0, 1, 0, 1, 4'd10, 32'h89AB_CDEF, "R10 second after idle");
    host_chk(4'd10, "R10 done");

    // Random transfers
    for (int n = 0; n < 400; n++) begin
      int unsigned kind = $urandom % 8;
      bit st = $urandom[0], it = $urandom[0], be = $urandom[0];
      logic [3:0] idx = 4'($urandom);
      if (kind == 0) host_chk(4'($urandom), "R2 R10 rnd idle");
      else if (kind == 1) beat(0, st, it, be, $urandom[0], idx, $urandom, "R7 rnd nondata");
      else if (kind < 4) begin
        beat(1, st, it, be, 0, idx, $urandom, "R8 R9 rnd short");
        host_chk(idx, "R8 R9 rnd short");
      end else begin
        beat(1, st, it, be, 1, idx, $urandom, "R4 R5 rnd long1");
        if (($urandom % 8) == 0) beat(0, st, it, be, 1, idx, $urandom, "R7 rnd break");
        beat(1, st, it, be, 1, idx, $urandom, "R4 R5 rnd long2");
        host_chk(idx, "R4 rnd long");
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule